// File: doc/BRIEF.md
# Four-Bank Row-Register Read Cache Controller

This block fronts a behavioural DRAM-style array that is divided into four independent banks. Each bank keeps one row of its array in a private register, along with a valid flag and the row number it holds. A read names a row and a column. The two most significant column bits choose the bank, and the row number is compared with that bank's stored row number. On a hit the byte is taken from the bank's register and returned on the next cycle. On a miss the controller stalls, waits a fixed fill time, copies the whole row into the register, records the new row number, and then returns the byte from the register. The array never drives read data directly.

Writes are accepted into a single posting register, and the requester moves on at once. The posting register drains into the array after a fixed number of cycles. If the written row is currently held by its bank's register, that register is updated in the same cycle the write is accepted, so later hits see the new data. A row fill for a bank waits until any posted write to that same bank has reached the array. A second write that arrives while the posting register is still occupied stalls. Reads are still accepted during that time.

The default parameters give a small array: 16 rows per bank and 16 columns. A full-size configuration uses 9 row bits and 8 column-index bits.

Top module: `rowcache_ctrl`

## Requirements
- R1: After reset, `ready` is high while no write is offered, `rsp_valid` is low, and every bank's stored row is invalid, so the first read to each bank is a miss.
- R2: The bank is `req_col[COL_W+1:COL_W]` and the column within the row is `req_col[COL_W-1:0]`. The same row and column index in different banks address different data, and each bank holds its open row independently of the others.
- R3: A read whose row equals its bank's valid stored row is a hit. It is accepted at once, and on the following cycle `rsp_valid`=1, `rsp_hit`=1 and `rsp_rdata` holds the addressed byte.
- R4: A read that misses, with no posted write pending to its bank, holds `ready` low. It returns `rsp_valid`=1 with `rsp_hit`=0 exactly FILL_CYCLES+2 cycles after acceptance, carrying the array byte. After that, the bank's stored row is the one that was read.
- R5: Once four rows are open, one per bank, reads that alternate among those rows in any bank order all hit with single-cycle latency.
- R6: A write (`req_write`=1) is accepted without waiting when the posting register is empty. It produces no response, and it reaches the array POST_CYCLES cycles later.
- R7: A write offered while the posting register is occupied sees `ready` low for exactly POST_CYCLES cycles after the previous write was accepted. A read offered in that window is accepted immediately.
- R8: A write to a row that is currently held by its bank updates that bank's register, so a read hit immediately afterwards returns the new byte.
- R9: A miss in a bank that has a posted write pending does not begin its fill until the write has reached the array. The returned byte reflects that write.
- R10: Each accepted read produces exactly one `rsp_valid` pulse of one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_write | input | 1 | 1 = write, 0 = read |
| req_row | input | ROW_W | Row number within the bank |
| req_col | input | COL_W+2 | Bank (top two bits) and column index |
| req_wdata | input | DATA_W | Write byte |
| ready | output | 1 | Request is accepted at this clock edge when high with req_valid |
| rsp_valid | output | 1 | One-cycle read response strobe |
| rsp_hit | output | 1 | Response came from an already open row |
| rsp_rdata | output | DATA_W | Read byte |

## Verification
The hardest situation to reach is a miss that has to wait for a posted write to its own bank. It needs a write to an uncached row, followed in the very next cycle by a read of that same row before the posting register drains. The bench sets this up by issuing the read directly after the write's acceptance cycle and expecting the freshly written byte back as a miss. The same back-to-back approach exposes the write-after-write stall length and the coherent register update. Full sweeps over every bank, row and column cover the bank decoding and the miss/hit pattern.

// File: rtl/rowcache_pkg.sv
package rowcache_pkg;
    localparam int BANKS  = 4;
    localparam int BANK_W = 2;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_FILL = 2'd2,
        ST_RESP = 2'd3
    } ctrl_st_e;
endpackage

// File: rtl/rc_array.sv
module rc_array
    import rowcache_pkg::*;
#(
    parameter int ROW_W  = 4,
    parameter int COL_W  = 4,
    parameter int DATA_W = 8
) (
    input  logic                        clk,
    input  logic                        we,
    input  logic [BANK_W-1:0]           wr_bank,
    input  logic [ROW_W-1:0]            wr_row,
    input  logic [COL_W-1:0]            wr_col,
    input  logic [DATA_W-1:0]           wr_data,
    input  logic [BANK_W-1:0]           rd_bank,
    input  logic [ROW_W-1:0]            rd_row,
    output logic [(1<<COL_W)*DATA_W-1:0] rd_line
);
    localparam int COLS  = 1 << COL_W;
    localparam int DEPTH = BANKS << (ROW_W + COL_W);

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[{wr_bank, wr_row, wr_col}] <= wr_data;
        end
    end

    for (genvar c = 0; c < COLS; c++) begin : g_col
        assign rd_line[c*DATA_W +: DATA_W] = mem[{rd_bank, rd_row, COL_W'(c)}];
    end
endmodule

// File: rtl/rc_rowreg.sv
module rc_rowreg #(
    parameter int ROW_W  = 4,
    parameter int COL_W  = 4,
    parameter int DATA_W = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         load,
    input  logic [ROW_W-1:0]             load_row,
    input  logic [(1<<COL_W)*DATA_W-1:0] load_line,
    input  logic                         wr_en,
    input  logic [COL_W-1:0]             wr_col,
    input  logic [DATA_W-1:0]            wr_data,
    input  logic [ROW_W-1:0]             look_row,
    output logic                         look_hit,
    input  logic [COL_W-1:0]             rd_col,
    output logic [DATA_W-1:0]            rd_data
);
    localparam int COLS = 1 << COL_W;

    typedef struct packed {
        logic             valid;
        logic [ROW_W-1:0] row;
    } tag_t;

    tag_t              tag_d, tag_q;
    logic [DATA_W-1:0] line_q [COLS];

    always_comb begin
        tag_d = tag_q;
        if (load) begin
            tag_d.valid = 1'b1;
            tag_d.row   = load_row;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag_q <= '0;
        end else begin
            tag_q <= tag_d;
        end
    end

    always_ff @(posedge clk) begin
        if (load) begin
            for (int c = 0; c < COLS; c++) begin
                line_q[c] <= load_line[c*DATA_W +: DATA_W];
            end
        end else if (wr_en) begin
            line_q[wr_col] <= wr_data;
        end
    end

    assign look_hit = tag_q.valid && (tag_q.row == look_row);
    assign rd_data  = line_q[rd_col];
endmodule

// File: rtl/rowcache_ctrl.sv
module rowcache_ctrl
    import rowcache_pkg::*;
#(
    parameter int ROW_W       = 4,
    parameter int COL_W       = 4,
    parameter int DATA_W      = 8,
    parameter int FILL_CYCLES = 3,
    parameter int POST_CYCLES = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    input  logic                    req_write,
    input  logic [ROW_W-1:0]        req_row,
    input  logic [COL_W+BANK_W-1:0] req_col,
    input  logic [DATA_W-1:0]       req_wdata,
    output logic                    ready,
    output logic                    rsp_valid,
    output logic                    rsp_hit,
    output logic [DATA_W-1:0]       rsp_rdata
);
    localparam int COLS   = 1 << COL_W;
    localparam int LINE_W = COLS * DATA_W;
    localparam int FCNT_W = (FILL_CYCLES > 1) ? $clog2(FILL_CYCLES) : 1;
    localparam int PCNT_W = (POST_CYCLES > 1) ? $clog2(POST_CYCLES) : 1;

    typedef struct packed {
        ctrl_st_e          st;
        logic [FCNT_W-1:0] fill_cnt;
        logic [BANK_W-1:0] pend_bank;
        logic [ROW_W-1:0]  pend_row;
        logic [COL_W-1:0]  pend_col;
        logic              post_full;
        logic [PCNT_W-1:0] post_cnt;
        logic [BANK_W-1:0] post_bank;
        logic [ROW_W-1:0]  post_row;
        logic [COL_W-1:0]  post_col;
        logic [DATA_W-1:0] post_data;
        logic              rsp_valid;
        logic              rsp_hit;
        logic [DATA_W-1:0] rsp_data;
    } ctrl_t;

    ctrl_t r_d, r_q;

    logic [BANK_W-1:0] req_bank;
    logic [COL_W-1:0]  req_cidx;
    logic [BANKS-1:0]  hit_vec;
    logic [BANKS-1:0]  load_vec;
    logic [BANKS-1:0]  wr_vec;
    logic [DATA_W-1:0] rr_data [BANKS];
    logic [LINE_W-1:0] arr_line;
    logic              look_hit;
    logic              acc_rd;
    logic              acc_wr;
    logic              arr_we;
    logic [BANK_W-1:0] sel_bank;
    logic [COL_W-1:0]  sel_col;
    logic [DATA_W-1:0] sel_data;
    logic              post_full_w;
    logic [BANK_W-1:0] post_bank_w;
    logic [BANK_W-1:0] fill_bank_w;

    assign req_bank = req_col[COL_W +: BANK_W];
    assign req_cidx = req_col[COL_W-1:0];

    // writes wait only on an occupied posting register; reads ignore it
    assign ready  = (r_q.st == ST_IDLE) && !(req_write && r_q.post_full);
    assign acc_rd = req_valid && ready && !req_write;
    assign acc_wr = req_valid && ready && req_write;

    assign look_hit = hit_vec[req_bank];
    assign arr_we   = r_q.post_full && (r_q.post_cnt == '0);

    assign sel_bank = (r_q.st == ST_RESP) ? r_q.pend_bank : req_bank;
    assign sel_col  = (r_q.st == ST_RESP) ? r_q.pend_col  : req_cidx;
    assign sel_data = rr_data[sel_bank];

    assign post_full_w = r_q.post_full;
    assign post_bank_w = r_q.post_bank;
    assign fill_bank_w = r_q.pend_bank;

    rc_array #(
        .ROW_W (ROW_W),
        .COL_W (COL_W),
        .DATA_W(DATA_W)
    ) u_array (
        .clk    (clk),
        .we     (arr_we),
        .wr_bank(r_q.post_bank),
        .wr_row (r_q.post_row),
        .wr_col (r_q.post_col),
        .wr_data(r_q.post_data),
        .rd_bank(r_q.pend_bank),
        .rd_row (r_q.pend_row),
        .rd_line(arr_line)
    );

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        assign load_vec[b] = (r_q.st == ST_FILL) && (r_q.fill_cnt == '0)
                             && (r_q.pend_bank == BANK_W'(b));
        assign wr_vec[b]   = acc_wr && (req_bank == BANK_W'(b));

        rc_rowreg #(
            .ROW_W (ROW_W),
            .COL_W (COL_W),
            .DATA_W(DATA_W)
        ) u_rowreg (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (load_vec[b]),
            .load_row (r_q.pend_row),
            .load_line(arr_line),
            .wr_en    (wr_vec[b] && hit_vec[b]),
            .wr_col   (req_cidx),
            .wr_data  (req_wdata),
            .look_row (req_row),
            .look_hit (hit_vec[b]),
            .rd_col   (sel_col),
            .rd_data  (rr_data[b])
        );
    end

    always_comb begin
        r_d           = r_q;
        r_d.rsp_valid = 1'b0;
        r_d.rsp_hit   = 1'b0;

        // posting register drain
        if (r_q.post_full) begin
            if (r_q.post_cnt == '0) begin
                r_d.post_full = 1'b0;
            end else begin
                r_d.post_cnt = r_q.post_cnt - 1'b1;
            end
        end
        if (acc_wr) begin
            r_d.post_full = 1'b1;
            r_d.post_cnt  = PCNT_W'(POST_CYCLES - 1);
            r_d.post_bank = req_bank;
            r_d.post_row  = req_row;
            r_d.post_col  = req_cidx;
            r_d.post_data = req_wdata;
        end

        case (r_q.st)
            ST_IDLE: begin
                if (acc_rd) begin
                    if (look_hit) begin
                        r_d.rsp_valid = 1'b1;
                        r_d.rsp_hit   = 1'b1;
                        r_d.rsp_data  = sel_data;
                    end else begin
                        r_d.pend_bank = req_bank;
                        r_d.pend_row  = req_row;
                        r_d.pend_col  = req_cidx;
                        if (r_q.post_full && (r_q.post_bank == req_bank)) begin
                            r_d.st = ST_WAIT;
                        end else begin
                            r_d.st       = ST_FILL;
                            r_d.fill_cnt = FCNT_W'(FILL_CYCLES - 1);
                        end
                    end
                end
            end
            ST_WAIT: begin
                if (!(r_q.post_full && (r_q.post_bank == r_q.pend_bank))) begin
                    r_d.st       = ST_FILL;
                    r_d.fill_cnt = FCNT_W'(FILL_CYCLES - 1);
                end
            end
            ST_FILL: begin
                if (r_q.fill_cnt == '0) begin
                    r_d.st = ST_RESP;
                end else begin
                    r_d.fill_cnt = r_q.fill_cnt - 1'b1;
                end
            end
            ST_RESP: begin
                r_d.rsp_valid = 1'b1;
                r_d.rsp_hit   = 1'b0;
                r_d.rsp_data  = sel_data;
                r_d.st        = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign rsp_valid = r_q.rsp_valid;
    assign rsp_hit   = r_q.rsp_hit;
    assign rsp_rdata = r_q.rsp_data;
endmodule

// File: rtl/rowcache_chk.sv
module rowcache_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       req_write,
    input logic       ready,
    input logic       rsp_valid,
    input logic       rsp_hit,
    input logic       look_hit,
    input logic [3:0] load_vec,
    input logic       post_full,
    input logic [1:0] post_bank,
    input logic [1:0] fill_bank
);
    // R3
    hit_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && ready && !req_write && look_hit) |=> (rsp_valid && rsp_hit));

    // R4
    miss_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && ready && !req_write && !look_hit) |=> (!ready && !rsp_valid));

    // R4
    single_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(load_vec));

    // R9
    fill_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|load_vec) |-> !(post_full && (post_bank == fill_bank)));

    // R6
    write_no_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && ready && req_write) |=> !rsp_valid);
endmodule

bind rowcache_ctrl rowcache_chk i_rowcache_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_write(req_write),
    .ready    (ready),
    .rsp_valid(rsp_valid),
    .rsp_hit  (rsp_hit),
    .look_hit (look_hit),
    .load_vec (load_vec),
    .post_full(post_full_w),
    .post_bank(post_bank_w),
    .fill_bank(fill_bank_w)
);

// File: tb/test_rowcache_ctrl.sv
`timescale 1ns/1ps
module test_rowcache_ctrl;
    localparam int RW = 4;
    localparam int CW = 4;
    localparam int DW = 8;
    localparam int FC = 3;
    localparam int PC = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [RW-1:0] req_row = '0;
    logic [CW+1:0] req_col = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          ready;
    logic          rsp_valid;
    logic          rsp_hit;
    logic [DW-1:0] rsp_rdata;

    int errs = 0;
    int checks = 0;

    logic [7:0] mem_m [4][16][16];
    bit         tv [4];
    int         tr [4];

    always #2 clk = ~clk;

    rowcache_ctrl #(
        .ROW_W(RW), .COL_W(CW), .DATA_W(DW),
        .FILL_CYCLES(FC), .POST_CYCLES(PC)
    ) i_rowcache_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write),
        .req_row(req_row), .req_col(req_col), .req_wdata(req_wdata),
        .ready(ready), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
        .rsp_rdata(rsp_rdata)
    );

    function automatic logic [7:0] pat(int b, int r, int c);
        return 8'((b * 61 + r * 17 + c * 5 + 3) & 255);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // called at a negedge, returns at a negedge
    task automatic do_write(input int b, input int r, input int c, input logic [7:0] d,
                            output int stall);
        req_valid = 1'b1; req_write = 1'b1;
        req_row = RW'(r); req_col = {2'(b), CW'(c)}; req_wdata = d;
        stall = 0;
        #1;
        while (!ready) begin
            @(negedge clk); #1; stall++;
        end
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        mem_m[b][r][c] = d;
    endtask

    task automatic do_read(input int b, input int r, input int c, input bit chk_lat,
                           input string tag, output int wt);
        bit         exp_hit;
        logic [7:0] exp_d;
        int         k;
        exp_hit = tv[b] && (tr[b] == r);
        exp_d   = mem_m[b][r][c];
        req_valid = 1'b1; req_write = 1'b0;
        req_row = RW'(r); req_col = {2'(b), CW'(c)};
        wt = 0;
        #1;
        while (!ready) begin
            @(negedge clk); #1; wt++;
        end
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        k = 1;
        while (!rsp_valid && k < 100) begin
            @(negedge clk); k++;
        end
        chk(rsp_valid, {tag, " R10 response"}, rsp_valid, 1);
        chk(rsp_hit == exp_hit, {tag, " hit flag"}, rsp_hit, exp_hit);
        chk(rsp_rdata == exp_d, {tag, " data"}, rsp_rdata, exp_d);
        if (chk_lat) begin
            chk(k == (exp_hit ? 1 : FC + 2), {tag, " latency"}, k, exp_hit ? 1 : FC + 2);
        end
        @(negedge clk);
        chk(!rsp_valid, "R10 single pulse", rsp_valid, 0);
        tv[b] = 1'b1;
        tr[b] = r;
    endtask

    initial begin
        #800000;
        errs++;
        checks++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        int st;
        int wt;
        for (int b = 0; b < 4; b++) begin
            tv[b] = 1'b0;
            tr[b] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk(ready == 1'b1, "R1 ready after reset", ready, 1);
        chk(rsp_valid == 1'b0, "R1 no response after reset", rsp_valid, 0);
        @(negedge clk);

        // R6 / R2: fill the whole array through the posting register
        for (int b = 0; b < 4; b++)
            for (int r = 0; r < 16; r++)
                for (int c = 0; c < 16; c++) begin
                    do_write(b, r, c, pat(b, r, c), st);
                    if (b == 0 && r == 0 && c == 0)
                        chk(st == 0, "R6 first write accepted at once", st, 0);
                    else
                        chk(st == PC, "R7 write stall length", st, PC);
                end
        @(negedge clk);
        @(negedge clk);

        // R1 R2 R3 R4: sweep every bank, row, column
        for (int b = 0; b < 4; b++)
            for (int r = 0; r < 16; r++)
                for (int c = 0; c < 16; c++)
                    do_read(b, r, c, 1'b1, (r == 0 && c == 0) ? "R1 first read" :
                            (c == 0) ? "R4 miss" : "R3 R2 hit", wt);

        // R5: one row open per bank, then alternate
        for (int b = 0; b < 4; b++)
            do_read(b, b + 3, 0, 1'b1, "R4 open", wt);
        for (int n = 0; n < 16; n++)
            do_read((n * 3) % 4, ((n * 3) % 4) + 3, n, 1'b1, "R5 alternate", wt);

        // R8 + R7: coherent update, read accepted while posting busy
        do_write(1, 4, 7, 8'h3C, st);
        do_read(1, 4, 7, 1'b1, "R8 coherent", wt);
        chk(wt == 0, "R7 read not stalled by posting", wt, 0);

        // R7: back-to-back writes
        do_write(0, 0, 0, 8'h11, st);
        do_write(0, 0, 1, 8'h22, st);
        chk(st == PC, "R7 second write stall", st, PC);
        @(negedge clk);
        @(negedge clk);

        // R9: miss behind a posted write to the same bank
        do_write(2, 9, 3, 8'hA5, st);
        do_read(2, 9, 3, 1'b0, "R9 ordered miss", wt);
        do_write(0, 0, 1, 8'h5A, st);
        do_read(0, 0, 1, 1'b0, "R9 ordered miss bank0", wt);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule